// File: doc/BRIEF.md
# Dual 8-bit Parallel Port with Strobe Handshake

This block is a two-port programmable parallel interface that sits on a processor bus. Each port owns an output latch, a per-pin direction register and a small control register. A pin whose direction bit is set drives the output latch toward the outside world. A pin whose direction bit is clear is an input, and its value can be captured by an external strobe.

When the handshake is enabled on a port, a rising edge on the port's strobe input (C1) captures the pins into an input latch. In the same clock edge the port raises its acknowledge output (C2) and holds an interrupt request pending. A processor read of that port's data register consumes the captured byte, drops the acknowledge and withdraws the request. A typical use is a keyboard on port A: the keyboard strobes each key code in, the handler reads it, and the falling acknowledge tells the keyboard to send the next code. Each port has its own active-low interrupt line, so the two ports can be served by separate handlers.

The handshake per port is a three-state machine. HS_IDLE means nothing is captured. HS_FULL means one byte is captured and unread. HS_OVER means a further strobe arrived before the read. The transitions are:
- HS_IDLE to HS_FULL on a strobe edge.
- HS_FULL to HS_OVER on a strobe edge without a read.
- HS_FULL or HS_OVER back to HS_IDLE on a data read without a strobe.
- HS_FULL or HS_OVER to HS_FULL on a data read and a strobe edge in the same cycle.
- Any state to HS_IDLE whenever the handshake is disabled.

Top module: `pario_hs`

## Requirements
- R1: After reset, both direction registers are 0 (all pins inputs), both control registers read 0, both output latches are 0, both acknowledge outputs are low and both interrupt outputs are high.
- R2: With ctl_sel=0, addr[1] picks the port (0=A, 1=B) and addr[0] picks the register (0=data, 1=direction). With ctl_sel=1 the control register of port addr[1] is accessed. A control read returns bit 0 = interrupt enable, bit 1 = handshake enable, bit 2 = overrun, and 0 in the upper bits. Only bits 1:0 are writable.
- R3: A direction bit of 1 makes that pin an output driven from the output latch (dir ports show the direction register). A data read returns the output latch on output bits and the input value on input bits.
- R4: With handshake enabled, the clock edge at which C1 is first sampled high after being sampled low captures the pins and sets C2 high. If interrupts are enabled, the same edge drives the interrupt output low.
- R5: A read of a port's data register, with no strobe edge in the same cycle, drops C2 and releases the interrupt at the following clock edge.
- R6: With interrupt enable 0, the interrupt output stays high while a request is pending. Setting the enable later drives the interrupt output low at the next edge.
- R7: A second strobe before the data read overwrites the captured data, keeps the request and C2 asserted, and sets the overrun bit. A data read clears the overrun bit.
- R8: With handshake disabled, strobes are ignored: C2 stays low, the interrupt stays high, and data reads return the live pin value on input bits.
- R9: The two ports are independent: a strobe or read on one port leaves the other port's C2 and interrupt output unchanged.
- R10: A strobe edge and a data read in the same cycle give the read the old byte and leave the new byte pending, with C2 high and the request asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Bus write strobe for one cycle |
| rd_en | input | 1 | Bus read strobe for one cycle (data reads consume) |
| ctl_sel | input | 1 | Selects the control register of port addr[1] |
| addr | input | 2 | Register select: bit 1 port, bit 0 data/direction |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the selected register |
| pa_in | input | 8 | Port A pin inputs |
| pa_out | output | 8 | Port A output latch |
| pa_dir | output | 8 | Port A pin directions, 1 = output |
| a_stb | input | 1 | Port A strobe (C1) |
| a_ack | output | 1 | Port A acknowledge (C2) |
| a_irq_n | output | 1 | Port A interrupt request, active low |
| pb_in | input | 8 | Port B pin inputs |
| pb_out | output | 8 | Port B output latch |
| pb_dir | output | 8 | Port B pin directions, 1 = output |
| b_stb | input | 1 | Port B strobe (C1) |
| b_ack | output | 1 | Port B acknowledge (C2) |
| b_irq_n | output | 1 | Port B interrupt request, active low |

## Verification
The bench builds the block with its default data width of 8. At that width the direction masks used (0xF0 on A, 0x0F on B) split every data read into a latch half and an input half. A single read therefore shows whether the direction rule, the input latch and the output latch each land in the right bits. The 8-bit width also leaves three control bits inside the field, so the overrun bit and the unwritable upper bits can be checked on the same read. Port A runs with the handshake on and port B with it off. This brings the full state machine on A, including the overrun and the strobe-during-read path, and the transparent input path on B into reach in one run.

// File: rtl/pario_pkg.sv
package pario_pkg;
    localparam int NPORT   = 2;
    localparam int CTL_IE  = 0;
    localparam int CTL_HS  = 1;
    localparam int CTL_OVR = 2;

    typedef enum logic [1:0] {
        HS_IDLE = 2'd0,
        HS_FULL = 2'd1,
        HS_OVER = 2'd2
    } hs_state_t;
endpackage

// File: rtl/pario_hs_fsm.sv
module pario_hs_fsm
    import pario_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hs_en,
    input  logic stb_edge,
    input  logic rd_clr,
    output logic latch_en,
    output logic pend,
    output logic ovr
);
    hs_state_t state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= HS_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            HS_IDLE: begin
                if (hs_en && stb_edge) state_nx = HS_FULL;
            end
            HS_FULL: begin
                if (!hs_en)                   state_nx = HS_IDLE;
                else if (stb_edge && !rd_clr) state_nx = HS_OVER;
                else if (stb_edge)            state_nx = HS_FULL;
                else if (rd_clr)              state_nx = HS_IDLE;
            end
            HS_OVER: begin
                if (!hs_en)                   state_nx = HS_IDLE;
                else if (stb_edge && rd_clr)  state_nx = HS_FULL;
                else if (rd_clr)              state_nx = HS_IDLE;
            end
            default: state_nx = HS_IDLE;
        endcase
    end

    always_comb begin
        latch_en = hs_en && stb_edge;
        pend     = (state != HS_IDLE);
        ovr      = (state == HS_OVER);
    end

    // R4: a strobe with handshake on leaves a pending request
    a_r4_strobe_pends: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_en && stb_edge) |=> pend);
    // R5: a read without strobe retires the request
    a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_en && rd_clr && !stb_edge) |=> !pend);
    // R7: strobe on a full buffer without a read flags overrun
    a_r7_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && hs_en && stb_edge && !rd_clr) |=> ovr);
    // R8: handshake off never leaves a request behind
    a_r8_off_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !hs_en |=> !pend);
endmodule

// File: rtl/pario_port.sv
module pario_port
    import pario_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_dat,
    input  logic          wr_dir,
    input  logic          wr_ctl,
    input  logic          rd_dat,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] pin_in,
    input  logic          stb,
    output logic [DW-1:0] pin_out,
    output logic [DW-1:0] dir,
    output logic [DW-1:0] dat_rd,
    output logic [DW-1:0] ctl_rd,
    output logic          ack,
    output logic          irq_n
);
    logic [DW-1:0] out_q, dir_q, in_q;
    logic          ie_q, hs_q, stb_q;
    logic          stb_edge, latch_en, pend, ovr;

    assign stb_edge = stb && !stb_q;

    pario_hs_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .hs_en    (hs_q),
        .stb_edge (stb_edge),
        .rd_clr   (rd_dat),
        .latch_en (latch_en),
        .pend     (pend),
        .ovr      (ovr)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
            dir_q <= '0;
            in_q  <= '0;
            ie_q  <= 1'b0;
            hs_q  <= 1'b0;
            stb_q <= 1'b0;
        end else begin
            stb_q <= stb;
            if (wr_dat)   out_q <= wdata;
            if (wr_dir)   dir_q <= wdata;
            if (wr_ctl) begin
                ie_q <= wdata[CTL_IE];
                hs_q <= wdata[CTL_HS];
            end
            if (latch_en) in_q <= pin_in;
        end
    end

    logic [DW-1:0] in_view;
    always_comb begin
        in_view = hs_q ? in_q : pin_in;
        dat_rd  = (dir_q & out_q) | (~dir_q & in_view);
        ctl_rd          = '0;
        ctl_rd[CTL_IE]  = ie_q;
        ctl_rd[CTL_HS]  = hs_q;
        ctl_rd[CTL_OVR] = ovr;
        pin_out = out_q;
        dir     = dir_q;
        ack     = pend;
        irq_n   = !(pend && ie_q);
    end

    // R4: the captured byte is the pin value at the strobe edge
    a_r4_capture: assert property (@(posedge clk) disable iff (!rst_n)
        latch_en |=> (in_q == $past(pin_in)));
    // R6: a request with interrupts enabled shows on the line
    a_r6_irq_line: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && $past(ie_q) && ie_q && $past(rst_n)) |-> !irq_n);
endmodule

// File: rtl/pario_hs.sv
module pario_hs
    import pario_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic          ctl_sel,
    input  logic [1:0]    addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    input  logic [DW-1:0] pa_in,
    output logic [DW-1:0] pa_out,
    output logic [DW-1:0] pa_dir,
    input  logic          a_stb,
    output logic          a_ack,
    output logic          a_irq_n,
    input  logic [DW-1:0] pb_in,
    output logic [DW-1:0] pb_out,
    output logic [DW-1:0] pb_dir,
    input  logic          b_stb,
    output logic          b_ack,
    output logic          b_irq_n
);
    logic [NPORT-1:0][DW-1:0] p_in, p_out, p_dir, p_dat, p_ctl;
    logic [NPORT-1:0]         p_stb, p_ack, p_irq;

    assign p_in  = {pb_in, pa_in};
    assign p_stb = {b_stb, a_stb};
    assign pa_out = p_out[0];
    assign pb_out = p_out[1];
    assign pa_dir = p_dir[0];
    assign pb_dir = p_dir[1];
    assign a_ack  = p_ack[0];
    assign b_ack  = p_ack[1];
    assign a_irq_n = p_irq[0];
    assign b_irq_n = p_irq[1];

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        logic hit;
        assign hit = (addr[1] == p[0]);
        pario_port #(.DW(DW)) u_port (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_dat  (wr_en && hit && !ctl_sel && !addr[0]),
            .wr_dir  (wr_en && hit && !ctl_sel &&  addr[0]),
            .wr_ctl  (wr_en && hit &&  ctl_sel),
            .rd_dat  (rd_en && hit && !ctl_sel && !addr[0]),
            .wdata   (wdata),
            .pin_in  (p_in[p]),
            .stb     (p_stb[p]),
            .pin_out (p_out[p]),
            .dir     (p_dir[p]),
            .dat_rd  (p_dat[p]),
            .ctl_rd  (p_ctl[p]),
            .ack     (p_ack[p]),
            .irq_n   (p_irq[p])
        );
    end

    always_comb begin
        if (ctl_sel)      rdata = p_ctl[addr[1]];
        else if (addr[0]) rdata = p_dir[addr[1]];
        else              rdata = p_dat[addr[1]];
    end

    // R9: a data read of one port leaves the other port's request alone
    a_r9_isolated: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !ctl_sel && !addr[0] && addr[1] && !a_stb && a_ack) |=> a_ack);
endmodule

// File: tb/pario_hs_tb.sv
module pario_hs_tb_top;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0, rd_en = 1'b0, ctl_sel = 1'b0;
    logic [1:0]    addr = '0;
    logic [DW-1:0] wdata = '0, rdata;
    logic [DW-1:0] pa_in = '0, pa_out, pa_dir, pb_in = '0, pb_out, pb_dir;
    logic          a_stb = 1'b0, b_stb = 1'b0;
    logic          a_ack, a_irq_n, b_ack, b_irq_n;

    int n_chk = 0, n_bad = 0;

    always #4 clk = ~clk;

    pario_hs #(.DW(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .ctl_sel(ctl_sel), .addr(addr), .wdata(wdata), .rdata(rdata),
        .pa_in(pa_in), .pa_out(pa_out), .pa_dir(pa_dir), .a_stb(a_stb),
        .a_ack(a_ack), .a_irq_n(a_irq_n),
        .pb_in(pb_in), .pb_out(pb_out), .pb_dir(pb_dir), .b_stb(b_stb),
        .b_ack(b_ack), .b_irq_n(b_irq_n)
    );

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic c, input logic [1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; ctl_sel = c; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic c, input logic [1:0] a, output logic [DW-1:0] d);
        @(negedge clk);
        rd_en = 1'b1; ctl_sel = c; addr = a;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    // strobe a port: raise C1 with pins set, lower it one cycle later
    task automatic strobe(input bit pb, input logic [DW-1:0] v);
        @(negedge clk);
        if (pb) begin pb_in = v; b_stb = 1'b1; end
        else    begin pa_in = v; a_stb = 1'b1; end
        @(negedge clk);
        a_stb = 1'b0; b_stb = 1'b0;
    endtask

    // vector: {wr, ctl, addr[1:0], data, expected}
    localparam int NV = 12;
    localparam logic [19:0] VEC [NV] = '{
        {1'b1, 1'b0, 2'b01, 8'hF0, 8'h00},
        {1'b1, 1'b0, 2'b00, 8'hA5, 8'h00},
        {1'b1, 1'b0, 2'b11, 8'h0F, 8'h00},
        {1'b1, 1'b0, 2'b10, 8'h5A, 8'h00},
        {1'b1, 1'b1, 2'b00, 8'hFF, 8'h00},
        {1'b1, 1'b1, 2'b10, 8'h01, 8'h00},
        {1'b0, 1'b0, 2'b01, 8'h00, 8'hF0},
        {1'b0, 1'b0, 2'b00, 8'h00, 8'hA0},
        {1'b0, 1'b0, 2'b11, 8'h00, 8'h0F},
        {1'b0, 1'b0, 2'b10, 8'h00, 8'hCA},
        {1'b0, 1'b1, 2'b00, 8'h00, 8'h03},
        {1'b0, 1'b1, 2'b10, 8'h00, 8'h01}
    };

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual expired expected done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [DW-1:0] d;
        pa_in = 8'h3C; pb_in = 8'hC3;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 a_ack", {7'd0, a_ack}, 8'h00);
        chk("R1 a_irq_n", {7'd0, a_irq_n}, 8'h01);
        chk("R1 b_irq_n", {7'd0, b_irq_n}, 8'h01);
        chk("R1 pa_dir", pa_dir, 8'h00);
        rst_n = 1'b1;
        bus_rd(1'b1, 2'b00, d); chk("R1 ctl A", d, 8'h00);
        bus_rd(1'b1, 2'b10, d); chk("R1 ctl B", d, 8'h00);

        // R2 / R3 register map and direction mixing vectors
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][19]) bus_wr(VEC[i][18], VEC[i][17:16], VEC[i][15:8]);
            else begin
                bus_rd(VEC[i][18], VEC[i][17:16], d);
                chk($sformatf("R2 R3 vector %0d", i), d, VEC[i][7:0]);
            end
        end
        chk("R3 pa_out", pa_out, 8'hA5);
        chk("R3 pb_dir", pb_dir, 8'h0F);

        // R4: strobe on A captures and acknowledges
        strobe(1'b0, 8'h3C);
        chk("R4 a_ack", {7'd0, a_ack}, 8'h01);
        chk("R4 a_irq_n", {7'd0, a_irq_n}, 8'h00);
        chk("R9 b_ack", {7'd0, b_ack}, 8'h00);
        chk("R9 b_irq_n", {7'd0, b_irq_n}, 8'h01);
        pa_in = 8'hFF;
        // R9: read of B data leaves A pending
        bus_rd(1'b0, 2'b10, d);
        chk("R9 a_ack kept", {7'd0, a_ack}, 8'h01);
        // R5: read returns captured value and clears
        bus_rd(1'b0, 2'b00, d);
        chk("R4 captured", d, 8'hAC);
        #1;
        chk("R5 a_ack", {7'd0, a_ack}, 8'h00);
        chk("R5 a_irq_n", {7'd0, a_irq_n}, 8'h01);

        // R7: overrun
        strobe(1'b0, 8'h11);
        strobe(1'b0, 8'h22);
        bus_rd(1'b1, 2'b00, d); chk("R7 ovr flag", d, 8'h07);
        chk("R7 irq held", {7'd0, a_irq_n}, 8'h00);
        bus_rd(1'b0, 2'b00, d); chk("R7 newest data", d, 8'hA2);
        bus_rd(1'b1, 2'b00, d); chk("R7 ovr cleared", d, 8'h03);

        // R6: interrupt enable gating
        bus_wr(1'b1, 2'b00, 8'h02);
        strobe(1'b0, 8'h0F);
        chk("R6 ack with ie=0", {7'd0, a_ack}, 8'h01);
        chk("R6 irq_n with ie=0", {7'd0, a_irq_n}, 8'h01);
        bus_wr(1'b1, 2'b00, 8'h03);
        chk("R6 irq after enable", {7'd0, a_irq_n}, 8'h00);

        // R10: strobe and read in the same cycle
        @(negedge clk);
        pa_in = 8'h05; a_stb = 1'b1; rd_en = 1'b1; ctl_sel = 1'b0; addr = 2'b00;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0; a_stb = 1'b0;
        chk("R10 old byte", d, 8'hAF);
        chk("R10 ack", {7'd0, a_ack}, 8'h01);
        chk("R10 irq_n", {7'd0, a_irq_n}, 8'h00);
        bus_rd(1'b0, 2'b00, d); chk("R10 new byte", d, 8'hA5);

        // R8: handshake off on B
        strobe(1'b1, 8'h77);
        chk("R8 b_ack", {7'd0, b_ack}, 8'h00);
        chk("R8 b_irq_n", {7'd0, b_irq_n}, 8'h01);
        pb_in = 8'hFF;
        bus_rd(1'b0, 2'b10, d); chk("R8 live pins", d, 8'hFA);

        // R1: reset while pending
        strobe(1'b0, 8'h99);
        @(negedge clk); rst_n = 1'b0;
        #1;
        chk("R1 ack after reset", {7'd0, a_ack}, 8'h00);
        chk("R1 irq after reset", {7'd0, a_irq_n}, 8'h01);
        chk("R1 dir after reset", pa_dir, 8'h00);
        chk("R1 out after reset", pb_out, 8'h00);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule